// File: doc/BRIEF.md
# Low-Voltage Detector Interrupt Controller

This block is the digital side of a supply monitor. An analog comparator reports, without any clock, whether the watched supply is above a programmed trip level. The block brings that bit into the clock domain and finds its rising and falling transitions. It latches the transitions that software selected into a sticky interrupt flag and drives one interrupt line from the flag after masking. The trip-level code and the input-source code are only held in a control register and driven out to the analog macro.

Software reaches the block through a simple synchronous read/write port. Writes take effect on the clock edge where they are presented. Read data is registered and appears one cycle after the request. Software can clear the flag, force it, mask it, and observe the raw, masked and comparator states. When the detector is switched on, a blanking window suppresses the false transitions that the comparator may produce while it settles.

Top module: `lvd_irq_ctrl`

## Requirements
- R1: After synchronous reset the control word, mask and interrupt flag are all zero, `irq` is 0, the trip and source outputs are 0 and `det_en` is 0.
- R2: Control word at address 0 keeps the trip code in bits [3:0], the edge select in bits [5:4], the source code in bits [10:8] and the enable in bit 15. It reads back as written, other bits read 0, and the trip code and enable drive `trip_sel` and `det_en`.
- R3: The source code drives `src_sel` unchanged, except code 3 (I/O supply, currently mapped to the core supply), which is driven out as 0.
- R4: The edge select is decoded as 0 = no events, 1 = rising transitions of the comparator, 2 = falling transitions, 3 = both.
- R5: Reading address 1 returns in bit 0 the synchronized comparator level: 1 means the supply is above the trip level and 0 means at or below it.
- R6: Address 2 returns the interrupt flag in bit 0. Writing 1 to bit 0 there clears it, and a read issued in the next cycle already returns 0.
- R7: Writing 1 to bit 0 of address 3 sets the interrupt flag whatever the comparator does.
- R8: Address 4 holds the mask in bit 0. Address 5 reads flag AND mask, and `irq` is that value registered one cycle later.
- R9: While the enable bit is 0, no comparator transition sets the flag.
- R10: When the enable goes from 0 to 1, transitions are ignored for BLANK_CYCLES clock cycles; later transitions are latched.
- R11: A hardware event and a software clear in the same cycle leave the flag set.
- R12: Read data appears one cycle after the read request, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| cmp_raw | input | 1 | Asynchronous comparator output, 1 = supply above trip level |
| trip_sel | output | 4 | Trip-level code to the reference ladder |
| src_sel | output | 3 | Input-source code to the analog multiplexer |
| det_en | output | 1 | Comparator enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BLANK_CYCLES set to 8 in place of the 20 us default. With that value the whole settling window, and the first edge after it, fall within a few dozen cycles. So a transition inside the window and one just after it can both be checked cheaply. DATA_W and ADDR_W keep their defaults, which place every field at the bit positions listed in the requirements.

// File: rtl/lvd_pkg.sv
package lvd_pkg;
  localparam int TRIP_W = 4;
  localparam int SRC_W  = 3;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_LEVEL  = 1;
  localparam int ADR_FLAG   = 2;
  localparam int ADR_FORCE  = 3;
  localparam int ADR_MASK   = 4;
  localparam int ADR_MASKED = 5;

  localparam int CB_TRIP_LO = 0;
  localparam int CB_EDGE_LO = 4;
  localparam int CB_SRC_LO  = 8;
  localparam int CB_EN      = 15;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_t;

  typedef struct packed {
    logic              en;
    logic [SRC_W-1:0]  src;
    edge_mode_t        edge_mode;
    logic [TRIP_W-1:0] trip;
  } ctrl_t;

  localparam logic [SRC_W-1:0] SRC_IO   = 3'd3;
  localparam logic [SRC_W-1:0] SRC_CORE = 3'd0;
endpackage

// File: rtl/lvd_sync_edge.sv
module lvd_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      prev  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], async_in};
      prev  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~prev;
  assign fall  = ~chain[STAGES-1] & prev;

  // R4: a rising transition is followed by a high previous sample
  a_r4_rise_tracks: assert property (@(posedge clk) disable iff (rst)
    rise |=> prev);
endmodule

// File: rtl/lvd_blank_timer.sv
module lvd_blank_timer #(
  parameter int BLANK_CYCLES = 4000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic quiet
);
  localparam int CW = $clog2(BLANK_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES);

  logic          en_d;
  logic [CW-1:0] cnt;
  logic          start;

  assign start = en & ~en_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_d <= 1'b0;
      cnt  <= '0;
    end else begin
      en_d <= en;
      if (!en)
        cnt <= '0;
      else if (start)
        cnt <= LOAD;
      else if (cnt != '0)
        cnt <= cnt - 1'b1;
    end
  end

  // events may pass only when enabled and the settle window has expired
  assign quiet = en & ~start & (cnt == '0);

  // R10: enable rising edge opens a blanking window
  a_r10_blank_opens: assert property (@(posedge clk) disable iff (rst)
    start |=> !quiet);
  // R9: detector disabled means no event window
  a_r9_off_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |-> !quiet);
endmodule

// File: rtl/lvd_irq_status.sv
module lvd_irq_status (
  input  logic clk,
  input  logic rst,
  input  logic hw_evt,
  input  logic sw_set,
  input  logic sw_clr,
  input  logic mask,
  output logic flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (hw_evt || sw_set)
        flag <= 1'b1;
      else if (sw_clr)
        flag <= 1'b0;
      irq <= flag & mask;
    end
  end

  // R11: event beats a simultaneous clear
  a_r11_evt_wins: assert property (@(posedge clk) disable iff (rst)
    hw_evt |=> flag);
  // R7: software force sets the flag
  a_r7_force: assert property (@(posedge clk) disable iff (rst)
    sw_set |=> flag);
  // R6: a lone clear drops the flag
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (sw_clr && !hw_evt && !sw_set) |=> !flag);
  // R8: the interrupt line needs the mask a cycle before
  a_r8_irq_masked: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(mask));
endmodule

// File: rtl/lvd_regs.sv
module lvd_regs
  import lvd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              level,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic              mask,
  output logic              sw_set,
  output logic              sw_clr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mask <= 1'b0;
    end else if (wr_en) begin
      if (addr == ADDR_W'(ADR_CTRL)) begin
        ctrl.trip      <= wdata[CB_TRIP_LO +: TRIP_W];
        ctrl.edge_mode <= edge_mode_t'(wdata[CB_EDGE_LO +: 2]);
        ctrl.src       <= wdata[CB_SRC_LO +: SRC_W];
        ctrl.en        <= wdata[CB_EN];
      end
      if (addr == ADDR_W'(ADR_MASK))
        mask <= wdata[0];
    end
  end

  assign sw_clr = wr_en && (addr == ADDR_W'(ADR_FLAG)) && wdata[0];
  assign sw_set = wr_en && (addr == ADDR_W'(ADR_FORCE)) && wdata[0];

  always_comb begin
    rd_mux = '0;
    case (int'(addr))
      ADR_CTRL: begin
        rd_mux[CB_TRIP_LO +: TRIP_W] = ctrl.trip;
        rd_mux[CB_EDGE_LO +: 2]      = ctrl.edge_mode;
        rd_mux[CB_SRC_LO +: SRC_W]   = ctrl.src;
        rd_mux[CB_EN]                = ctrl.en;
      end
      ADR_LEVEL:  rd_mux[0] = level;
      ADR_FLAG:   rd_mux[0] = flag;
      ADR_FORCE:  rd_mux[0] = flag;
      ADR_MASK:   rd_mux[0] = mask;
      ADR_MASKED: rd_mux[0] = flag & mask;
      default:    rd_mux    = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd_en)
      rdata <= rd_mux;
    else
      rdata <= '0;
  end

  // R12: without a request the read bus returns to zero
  a_r12_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

// File: rtl/lvd_irq_ctrl.sv
module lvd_irq_ctrl
  import lvd_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 3,
  parameter int SYNC_STAGES  = 2,
  parameter int BLANK_CYCLES = 4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              cmp_raw,
  output logic [3:0]        trip_sel,
  output logic [2:0]        src_sel,
  output logic              det_en,
  output logic              irq
);
  ctrl_t ctrl;
  logic  mask, sw_set, sw_clr, flag;
  logic  level, rise, fall, quiet, hw_evt;

  lvd_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(cmp_raw),
    .level(level), .rise(rise), .fall(fall)
  );

  lvd_blank_timer #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk(clk), .rst(rst), .en(ctrl.en), .quiet(quiet)
  );

  lvd_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .level(level), .flag(flag), .ctrl(ctrl), .mask(mask),
    .sw_set(sw_set), .sw_clr(sw_clr), .rdata(rdata)
  );

  always_comb begin
    unique case (ctrl.edge_mode)
      EDGE_RISE: hw_evt = quiet & rise;
      EDGE_FALL: hw_evt = quiet & fall;
      EDGE_BOTH: hw_evt = quiet & (rise | fall);
      default:   hw_evt = 1'b0;
    endcase
  end

  lvd_irq_status u_stat (
    .clk(clk), .rst(rst), .hw_evt(hw_evt), .sw_set(sw_set),
    .sw_clr(sw_clr), .mask(mask), .flag(flag), .irq(irq)
  );

  assign trip_sel = ctrl.trip;
  assign det_en   = ctrl.en;
  assign src_sel  = (ctrl.src == SRC_IO) ? SRC_CORE : ctrl.src;

  // R9: a disabled detector never latches a hardware event
  a_r9_no_evt_off: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |-> !hw_evt);
  // R3: the I/O-supply code never reaches the multiplexer
  a_r3_io_remap: assert property (@(posedge clk) disable iff (rst)
    src_sel != SRC_IO);
endmodule

// File: tb/lvd_irq_ctrl_test.sv
module lvd_irq_ctrl_test;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam int BLANK = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic cmp_raw = 1'b0;
  logic [3:0] trip_sel;
  logic [2:0] src_sel;
  logic det_en, irq;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] rv;

  always #2.5 clk = ~clk;

  lvd_irq_ctrl #(.DATA_W(DW), .ADDR_W(AW), .BLANK_CYCLES(BLANK)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_raw(cmp_raw), .trip_sel(trip_sel),
    .src_sel(src_sel), .det_en(det_en), .irq(irq)
  );

  // vector: {edge[1:0], cmp_before, cmp_after, expected_flag}
  localparam logic [4:0] VEC [8] = '{
    5'b00_01_0, 5'b00_10_0,
    5'b01_01_1, 5'b01_10_0,
    5'b10_01_0, 5'b10_10_1,
    5'b11_01_1, 5'b11_10_1
  };

  task automatic chk(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] cw(input bit en, input int src, input int edg, input int trip);
    return (DW'(en) << 15) | (DW'(src) << 8) | (DW'(edg) << 4) | DW'(trip);
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", DW'(irq), 0);
    chk("R1 det_en", DW'(det_en), 0);
    chk("R1 trip", DW'(trip_sel), 0);
    rd(0, rv); chk("R1 ctrl", rv, 0);
    rd(2, rv); chk("R1 flag", rv, 0);
    // R12 unmapped address
    rd(7, rv); chk("R12 unmapped", rv, 0);

    // R2 fields and R3 source mapping
    wr(0, cw(1'b0, 5, 2, 4'hA) | 32'h0001_0000);
    rd(0, rv); chk("R2 readback", rv, cw(1'b0, 5, 2, 4'hA));
    chk("R2 trip out", DW'(trip_sel), 32'hA);
    chk("R3 src pass", DW'(src_sel), 5);
    wr(0, cw(1'b0, 3, 0, 4'h3));
    chk("R3 io remap", DW'(src_sel), 0);

    // R9 disabled detector ignores transitions
    wr(0, cw(1'b0, 0, 3, 0));
    cmp_raw = 1'b1; idle(6);
    rd(2, rv); chk("R9 disabled", rv, 0);
    // R5 level view
    rd(1, rv); chk("R5 level high", rv, 1);
    cmp_raw = 1'b0; idle(6);
    rd(1, rv); chk("R5 level low", rv, 0);

    // R10 blanking: transition right after enable is dropped
    wr(0, cw(1'b1, 0, 3, 0));
    chk("R2 det_en", DW'(det_en), 1);
    cmp_raw = 1'b1; idle(6);
    rd(2, rv); chk("R10 blanked", rv, 0);
    idle(2 * BLANK);
    cmp_raw = 1'b0; idle(6);
    rd(2, rv); chk("R10 after window", rv, 1);

    // R4 table of edge modes
    for (int i = 0; i < 8; i++) begin
      wr(0, cw(1'b1, 0, int'(VEC[i][4:3]), 0));
      cmp_raw = VEC[i][2]; idle(6);
      wr(2, 1);
      cmp_raw = VEC[i][1]; idle(6);
      rd(2, rv); chk($sformatf("R4 vec %0d", i), rv, DW'(VEC[i][0]));
    end

    // R6 clear then immediate read
    wr(3, 1);
    @(negedge clk); wr_en = 1'b1; addr = AW'(2); wdata = 1;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b1; addr = AW'(2);
    @(negedge clk); rd_en = 1'b0;
    chk("R6 read after clear", rdata, 0);

    // R7 force while comparator idle, R8 mask and interrupt
    wr(0, cw(1'b1, 0, 0, 0));
    wr(3, 1);
    rd(2, rv); chk("R7 forced", rv, 1);
    rd(5, rv); chk("R8 masked off", rv, 0);
    chk("R8 irq masked", DW'(irq), 0);
    wr(4, 1);
    rd(5, rv); chk("R8 masked on", rv, 1);
    chk("R8 irq on", DW'(irq), 1);
    wr(2, 1); @(negedge clk);
    chk("R8 irq drops", DW'(irq), 0);

    // R11 event and clear on the same edge
    wr(0, cw(1'b1, 0, 1, 0));
    cmp_raw = 1'b0; idle(6);
    wr(2, 1);
    @(negedge clk); cmp_raw = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = AW'(2); wdata = 1;
    @(negedge clk); wr_en = 1'b0;
    rd(2, rv); chk("R11 event wins", rv, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule